// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block does packed integer and fixed-point arithmetic on one register-width operand pair. The register width is 32 or 64 bits. The two source words are split into independent lanes of 8, 16 or 32 bits. Every lane gets the same operation: add, subtract, minimum, maximum, arithmetic or logical right shift, or left shift. Add, subtract and left shift can clamp to the lane's range instead of wrapping. Right shifts can round to nearest instead of truncating. Two whole-word operations, byte swap and bit reverse, ignore the lane size.

The datapath is combinational and its result is captured in an output register. The result and its valid strobe appear one clock after the request. A sticky flag records that at least one lane was clamped since software last cleared it. Operands come from the ordinary general-purpose register file, so there is no extra operand storage.

Top module: `simd_sat_alu`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result` loads only on a cycle with `in_valid` high and otherwise keeps its value. Synchronous `rst` clears `result`, `out_valid` and `sat_flag` to zero.
- R2: `lane_sel` picks the lane width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 also means 32 bits. Lanes are computed independently, and no carry, borrow or shifted bit crosses a lane boundary.
- R3: Opcode 0 (add) and opcode 1 (subtract) with `sat_en` low wrap modulo the lane width and never report a clamp.
- R4: With `sat_en` high and `is_signed` high, an add or subtract that overflows gives the most positive lane value (0x7F..F) or the most negative lane value (0x80..0), depending on the direction of the overflow.
- R5: With `sat_en` high and `is_signed` low, an add that carries out gives all ones, and a subtract that borrows gives zero.
- R6: Opcode 2 gives the lane-wise minimum and opcode 3 the lane-wise maximum. The compare is signed when `is_signed` is high and unsigned otherwise.
- R7: Opcode 4 (arithmetic right shift) and opcode 5 (logical right shift) move every lane by the low log2(lane width) bits of `src_b`. All higher bits of `src_b` are ignored.
- R8: With `rnd_en` high, a right shift by a nonzero amount adds the last bit shifted out, the one just below the new LSB. A shift of zero is never changed by rounding.
- R9: Opcode 6 shifts left. With `sat_en` high, a lane that would lose significant bits or change sign clamps: a signed lane goes to its most positive or most negative value according to the sign of the input, and an unsigned lane goes to all ones.
- R10: Opcode 7 reverses the byte order of the whole word and opcode 8 reverses its bit order, both regardless of `lane_sel`. Neither ever reports a clamp.
- R11: `sat_flag` becomes set one clock after any accepted request (`in_valid` high) in which any lane clamped. It stays set until `flag_clr` is high at a clock edge, and `flag_clr` wins over a clamp in the same cycle.
- R12: Opcodes 9 to 15 give a zero result and never report a clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| lane_sel | input | 2 | Lane width select |
| is_signed | input | 1 | Signed interpretation of lanes |
| sat_en | input | 1 | Clamp instead of wrap |
| rnd_en | input | 1 | Round right shifts |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand or shift amount |
| flag_clr | input | 1 | Clear for the sticky clamp flag |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | XLEN | Registered result word |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The bench places a wrapping lane next to a carrying one, such as 0xFF+0x01 beside 0x01+0x01. A design that leaks carries across lanes would then corrupt the upper byte. It also drives signed overflows in both directions, unsigned overflows and underflows, and left shifts that lose bits or flip the sign. A clamp rule that is inverted or missing would show up as a wrapped value or a wrong flag. Rounding is checked at shift amounts of zero and nonzero, where a design adding the wrong bit would be off by one. The bench also checks shift amounts with junk in the high bits and a clear that arrives together with a clamp, which a design giving the clear lower priority would leave set.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MIN   = 4'd2,
        OP_MAX   = 4'd3,
        OP_SRA   = 4'd4,
        OP_SRL   = 4'd5,
        OP_SLL   = 4'd6,
        OP_BSWAP = 4'd7,
        OP_BREV  = 4'd8
    } simd_op_e;

    typedef enum logic [1:0] {
        LS_8   = 2'd0,
        LS_16  = 2'd1,
        LS_32  = 2'd2,
        LS_RSV = 2'd3
    } lane_sz_e;

    localparam int NUM_SIZES = 3;

    typedef struct packed {
        simd_op_e op;
        logic     sgn;
        logic     sat;
        logic     rnd;
    } simd_ctrl_t;

    // Index into the per-size result array; the reserved code folds onto 32 bits.
    function automatic logic [1:0] size_index(input lane_sz_e ls);
        case (ls)
            LS_8:    return 2'd0;
            LS_16:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic is_lane_op(input simd_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MIN) ||
               (op == OP_MAX) || (op == OP_SRA) || (op == OP_SRL) ||
               (op == OP_SLL);
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  simd_ctrl_t           ctrl,
    input  logic [$clog2(W)-1:0] sh,
    output logic [W-1:0]         y,
    output logic                 clamp
);
    localparam int S = $clog2(W);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] UMAX = {W{1'b1}};

    logic [W:0]   ext_a, ext_b, sum, dif;
    logic         add_ovf, sub_ovf, a_lt_b;
    logic [W-1:0] add_sat, sub_sat;
    logic signed [W-1:0] sra_v, sll_back;
    logic [W-1:0] srl_v, below, shl_v, shl_sat;
    logic         rbit, shl_lost;

    // Sign- or zero-extend one bit so overflow and ordering are exact.
    always_comb begin
        ext_a = ctrl.sgn ? {a[W-1], a} : {1'b0, a};
        ext_b = ctrl.sgn ? {b[W-1], b} : {1'b0, b};
        sum   = ext_a + ext_b;
        dif   = ext_a - ext_b;
        a_lt_b = dif[W];
    end

    always_comb begin
        if (ctrl.sgn) begin
            add_ovf = sum[W] ^ sum[W-1];
            sub_ovf = dif[W] ^ dif[W-1];
            add_sat = sum[W] ? SMIN : SMAX;
            sub_sat = dif[W] ? SMIN : SMAX;
        end else begin
            add_ovf = sum[W];
            sub_ovf = dif[W];
            add_sat = UMAX;
            sub_sat = '0;
        end
    end

    // Right shifts with optional round-half-up on the dropped bit.
    always_comb begin
        sra_v = $signed(a) >>> sh;
        srl_v = a >> sh;
        below = (sh == '0) ? '0 : (a >> (sh - 1'b1));
        rbit  = ctrl.rnd & below[0];
    end

    // Left shift: detect lost significance by shifting back.
    always_comb begin
        shl_v    = a << sh;
        sll_back = $signed(shl_v) >>> sh;
        if (ctrl.sgn)
            shl_lost = (sll_back != $signed(a));
        else
            shl_lost = ((shl_v >> sh) != a);
        if (ctrl.sgn)
            shl_sat = a[W-1] ? SMIN : SMAX;
        else
            shl_sat = UMAX;
    end

    always_comb begin
        y     = '0;
        clamp = 1'b0;
        case (ctrl.op)
            OP_ADD: begin
                if (ctrl.sat && add_ovf) begin
                    y     = add_sat;
                    clamp = 1'b1;
                end else begin
                    y = sum[W-1:0];
                end
            end
            OP_SUB: begin
                if (ctrl.sat && sub_ovf) begin
                    y     = sub_sat;
                    clamp = 1'b1;
                end else begin
                    y = dif[W-1:0];
                end
            end
            OP_MIN: y = a_lt_b ? a : b;
            OP_MAX: y = a_lt_b ? b : a;
            OP_SRA: y = sra_v + {{(W-1){1'b0}}, rbit};
            OP_SRL: y = srl_v + {{(W-1){1'b0}}, rbit};
            OP_SLL: begin
                if (ctrl.sat && shl_lost) begin
                    y     = shl_sat;
                    clamp = 1'b1;
                end else begin
                    y = shl_v;
                end
            end
            default: y = '0;
        endcase
    end

    logic unused_s;
    assign unused_s = (S == 0);

endmodule

// File: rtl/simd_perm.sv
module simd_perm #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] word,
    output logic [XLEN-1:0] bswap,
    output logic [XLEN-1:0] brev
);
    localparam int NB = XLEN / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign bswap[i*8 +: 8] = word[(NB-1-i)*8 +: 8];
    end

    for (genvar j = 0; j < XLEN; j++) begin : g_bit
        assign brev[j] = word[XLEN-1-j];
    end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
    import simd_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  simd_ctrl_t      ctrl,
    input  lane_sz_e        lane_sz,
    output logic [XLEN-1:0] res,
    output logic            clamp
);
    logic [XLEN-1:0]      size_res [NUM_SIZES];
    logic [NUM_SIZES-1:0] size_clamp;
    logic [XLEN-1:0]      perm_bswap, perm_brev;
    logic [1:0]           sidx;

    // One full bank of lanes per supported width; the mux below picks one.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int W  = 8 << g;
        localparam int NL = XLEN / W;
        localparam int S  = $clog2(W);
        logic [XLEN-1:0] r;
        logic [NL-1:0]   c;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            simd_lane #(.W(W)) u_lane (
                .a     (src_a[l*W +: W]),
                .b     (src_b[l*W +: W]),
                .ctrl  (ctrl),
                .sh    (src_b[S-1:0]),
                .y     (r[l*W +: W]),
                .clamp (c[l])
            );
        end
        assign size_res[g]   = r;
        assign size_clamp[g] = |c;
    end

    simd_perm #(.XLEN(XLEN)) u_perm (
        .word  (src_a),
        .bswap (perm_bswap),
        .brev  (perm_brev)
    );

    always_comb begin
        sidx  = size_index(lane_sz);
        res   = '0;
        clamp = 1'b0;
        if (is_lane_op(ctrl.op)) begin
            res   = size_res[sidx];
            clamp = size_clamp[sidx];
        end else if (ctrl.op == OP_BSWAP) begin
            res = perm_bswap;
        end else if (ctrl.op == OP_BREV) begin
            res = perm_brev;
        end
    end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
    import simd_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [1:0]      lane_sel,
    input  logic            is_signed,
    input  logic            sat_en,
    input  logic            rnd_en,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            flag_clr,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            sat_flag
);
    simd_ctrl_t      ctrl;
    logic [XLEN-1:0] dp_res;
    logic            dp_clamp;

    always_comb begin
        ctrl.op  = simd_op_e'(op);
        ctrl.sgn = is_signed;
        ctrl.sat = sat_en;
        ctrl.rnd = rnd_en;
    end

    simd_datapath #(.XLEN(XLEN)) u_dp (
        .src_a   (src_a),
        .src_b   (src_b),
        .ctrl    (ctrl),
        .lane_sz (lane_sz_e'(lane_sel)),
        .res     (dp_res),
        .clamp   (dp_clamp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= dp_res;
            if (flag_clr)
                sat_flag <= 1'b0;
            else if (in_valid && dp_clamp)
                sat_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/simd_sat_alu_checker.sv
module simd_sat_alu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            flag_clr,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            sat_flag
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !flag_clr) |=> sat_flag); // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !sat_flag); // R11
    AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !sat_flag) |=> !sat_flag); // R11
endmodule

bind simd_sat_alu simd_sat_alu_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .flag_clr  (flag_clr),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/simd_sat_alu_bench.sv
module simd_sat_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NVEC = 21;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  ls;
        logic        sg;
        logic        st;
        logic        rd;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] y;
        logic        f;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h02008081, 1'b0, 4'd3},  // R3 R2 wrap, no cross-lane carry
        '{4'd0, 2'd0, 1'b1, 1'b1, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h02007F81, 1'b1, 4'd4},  // R4
        '{4'd0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h02FF8081, 1'b1, 4'd5},  // R5
        '{4'd1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h00050010, 32'h00060008, 32'h00000008, 1'b1, 4'd5},  // R5
        '{4'd1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h80000010, 32'h00010020, 32'h8000FFF0, 1'b1, 4'd4},  // R4
        '{4'd0, 2'd2, 1'b1, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'd4},  // R4
        '{4'd2, 2'd0, 1'b1, 1'b0, 1'b0, 32'h807F01FF, 32'h018002FE, 32'h808001FE, 1'b0, 4'd6},  // R6
        '{4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 32'h807F01FF, 32'h018002FE, 32'h808002FF, 1'b0, 4'd6},  // R6
        '{4'd4, 2'd1, 1'b1, 1'b0, 1'b1, 32'hFFF90007, 32'h00000001, 32'hFFFD0004, 1'b0, 4'd8},  // R8
        '{4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 32'h80FF0F01, 32'h00000004, 32'h080F0000, 1'b0, 4'd7},  // R7
        '{4'd5, 2'd0, 1'b0, 1'b0, 1'b1, 32'h80FF0F01, 32'h00000004, 32'h08100100, 1'b0, 4'd8},  // R8
        '{4'd6, 2'd0, 1'b1, 1'b1, 1'b0, 32'h20E0C001, 32'h00000002, 32'h7F808004, 1'b1, 4'd9},  // R9
        '{4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 32'h20E0C001, 32'h00000002, 32'h80800004, 1'b0, 4'd9},  // R9
        '{4'd6, 2'd1, 1'b0, 1'b1, 1'b0, 32'h10000FFF, 32'h00000004, 32'hFFFFFFF0, 1'b1, 4'd9},  // R9
        '{4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 32'h12345678, 32'h00000000, 32'h78563412, 1'b0, 4'd10}, // R10
        '{4'd8, 2'd2, 1'b0, 1'b0, 1'b0, 32'h000000F1, 32'h00000000, 32'h8F000000, 1'b0, 4'd10}, // R10
        '{4'd5, 2'd1, 1'b0, 1'b0, 1'b0, 32'h80000002, 32'h00000011, 32'h40000001, 1'b0, 4'd7},  // R7 high shift bits ignored
        '{4'd15, 2'd0, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd12}, // R12
        '{4'd0, 2'd3, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1, 4'd2},  // R2 code 3 acts as 32
        '{4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h80000000, 32'h01000000, 32'h7F000000, 1'b0, 4'd3},  // R3 signed wrap
        '{4'd4, 2'd0, 1'b1, 1'b0, 1'b1, 32'h8100FF7F, 32'h00000000, 32'h8100FF7F, 1'b0, 4'd8}   // R8 zero shift
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [3:0]      op;
    logic [1:0]      lane_sel;
    logic            is_signed, sat_en, rnd_en, flag_clr;
    logic [XLEN-1:0] src_a, src_b;
    logic            out_valid;
    logic [XLEN-1:0] result;
    logic            sat_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_sat_alu #(.XLEN(XLEN)) u_simd_sat_alu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .lane_sel  (lane_sel),
        .is_signed (is_signed),
        .sat_en    (sat_en),
        .rnd_en    (rnd_en),
        .src_a     (src_a),
        .src_b     (src_b),
        .flag_clr  (flag_clr),
        .out_valid (out_valid),
        .result    (result),
        .sat_flag  (sat_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [1:0] ls, input logic sg,
                         input logic st, input logic rd, input logic [31:0] a,
                         input logic [31:0] b);
        op = o; lane_sel = ls; is_signed = sg; sat_en = st; rnd_en = rd;
        src_a = a; src_b = b;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; flag_clr = 1'b0;
        drive(4'd0, 2'd0, 1'b0, 1'b0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset result", result, 32'h0);
        check("R1", "reset out_valid", {31'b0, out_valid}, 32'h0);
        check("R11", "reset sat_flag", {31'b0, sat_flag}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            flag_clr = 1'b1; in_valid = 1'b0;
            @(negedge clk);
            flag_clr = 1'b0; in_valid = 1'b1;
            drive(VECS[i].op, VECS[i].ls, VECS[i].sg, VECS[i].st, VECS[i].rd,
                  VECS[i].a, VECS[i].b);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d result", i),
                  result, VECS[i].y);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d flag", i),
                  {31'b0, sat_flag}, {31'b0, VECS[i].f});
            check("R1", $sformatf("vec %0d out_valid", i), {31'b0, out_valid}, 32'h1);
        end

        // R1 hold: no load and valid low when in_valid is low
        drive(4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h11111111, 32'h11111111);
        @(negedge clk);
        check("R1", "hold result", result, VECS[NVEC-1].y);
        check("R1", "idle out_valid", {31'b0, out_valid}, 32'h0);

        // R11 clamp without in_valid leaves the flag clear
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        drive(4'd0, 2'd2, 1'b1, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        @(negedge clk);
        check("R11", "flag without valid", {31'b0, sat_flag}, 32'h0);

        // R11 set, then stay set across a clean op
        in_valid = 1'b1;
        @(negedge clk);
        drive(4'd0, 2'd2, 1'b1, 1'b1, 1'b0, 32'h1, 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "sticky after clean op", {31'b0, sat_flag}, 32'h1);
        check("R4", "clean op result", result, 32'h2);

        // R11 clear wins over a same-cycle clamp
        drive(4'd0, 2'd2, 1'b1, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        in_valid = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
        check("R11", "clear priority", {31'b0, sat_flag}, 32'h0);
        check("R4", "clamp under clear", result, 32'h7FFFFFFF);
        @(negedge clk);
        check("R11", "stays clear", {31'b0, sat_flag}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule